// File: doc/BRIEF.md
# Chainable Active-Low Priority Encoder

This block is a purely combinational priority encoder with active-low signals throughout. Each eight-line slice finds the most significant request line that is driven low and reports its position as an inverted binary code. The slice also has an enable input that forces every output high, a group flag that goes low when any request is present, and a pass-on output. The pass-on output goes low only when the slice is enabled and sees no request, so the next slice down may encode.

The top level chains a parameterised number of slices, from the highest-order slice down to the lowest. The pass-on output of each slice drives the enable of the slice below it. The merge stage adds the slice-select bits above the three per-slice code bits. It forms the combined three low code bits as the bitwise AND of all slice codes, which works because every slice that is not encoding drives all-high. The result is a wide encoder that behaves exactly like a flat priority encoder over `8*N_SLICES` lines.

Top module: `prio_enc_chain`

## Requirements
- R1: When `grp_n` is low, the request line whose index is the bitwise inverse of `code_n` is low.
- R2: When `grp_n` is low, every request line with a higher index than the encoded one is high, so the most significant low line wins.
- R3: While `en_in_n` is high, `code_n`, `grp_n` and `en_out_n` are all high, whatever the requests are.
- R4: While `en_in_n` is low, `grp_n` is low exactly when at least one bit of `req_n` is low.
- R5: While `en_in_n` is low, `en_out_n` is low exactly when every bit of `req_n` is high, so `grp_n` and `en_out_n` are never low together.
- R6: When enabled with no request, `code_n` is all ones.
- R7: Changing request lines below the highest low line does not change `code_n`.
- R8: The chained encoder gives the same `code_n`, `grp_n` and `en_out_n` as a flat encoder over all `8*N_SLICES` lines. Line index i maps to `code_n = ~i`, with the slice number in the upper `$clog2(N_SLICES)` bits and the line within the slice in the low three bits.
- R9: A single eight-line slice on its own meets R1 to R7, with a 3-bit code.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| req_n | input | 8*N_SLICES | Request lines, active low, the highest index has priority |
| en_in_n | input | 1 | Enable, active low |
| code_n | output | 3+$clog2(N_SLICES) | Inverted index of the winning request |
| grp_n | output | 1 | Low when enabled and any request is present |
| en_out_n | output | 1 | Low when enabled and no request is present, for chaining |

## Verification
The block holds no state, so a wrong internal value can only be a fault in the decode or in the chaining, and it shows at the ports in the same evaluation as the input that exposes it. A broken enable chain shows as two slices encoding at once: the code bits take the AND of two codes, and the encoded line then no longer matches a low request. A broken group flag shows as `grp_n` and `en_out_n` agreeing with each other.

// File: rtl/prio_enc_pkg.sv
// Shared constants for the chainable priority encoder.
// Assumes the slice width stays at eight lines with a three-bit code.
package prio_enc_pkg;
    localparam int SLICE_W  = 8;
    localparam int SLICE_CW = $clog2(SLICE_W);
endpackage

// File: rtl/prio_slice8.sv
// One eight-line active-low priority slice.
// Assumes: req_n bit 7 has the highest priority; all ports are active low.
// When disabled, every output is high. When enabled with no request,
// only eo_n goes low.
module prio_slice8
    import prio_enc_pkg::*;
(
    input  logic [SLICE_W-1:0]  req_n,
    input  logic                ei_n,
    output logic [SLICE_CW-1:0] code_n,
    output logic                gs_n,
    output logic                eo_n
);
    logic                enabled;
    logic                any_req;
    logic [SLICE_CW-1:0] win_idx;

    // Find the highest-index low line; the last hit in the ascending scan wins.
    always_comb begin
        win_idx = '0;
        any_req = 1'b0;
        for (int i = 0; i < SLICE_W; i++) begin
            if (!req_n[i]) begin
                win_idx = SLICE_CW'(i);
                any_req = 1'b1;
            end
        end
    end

    // Drive the code and the flags, all gated by the enable.
    always_comb begin
        enabled = !ei_n;
        code_n  = (enabled && any_req) ? ~win_idx : '1;
        gs_n    = !(enabled && any_req);
        eo_n    = !(enabled && !any_req);
    end
endmodule

// File: rtl/prio_merge.sv
// Merges the outputs of chained slices into one wide code.
// Assumes at most one slice has gs_n low, because the enable chain
// guarantees it, and that an idle or disabled slice drives an all-high code.
module prio_merge
    import prio_enc_pkg::*;
#(
    parameter int N_SLICES = 2,
    localparam int SEL_W   = $clog2(N_SLICES),
    localparam int CODE_W  = SLICE_CW + SEL_W
) (
    input  logic [N_SLICES*SLICE_CW-1:0] slice_code_n,
    input  logic [N_SLICES-1:0]          slice_gs_n,
    input  logic                         low_eo_n,
    output logic [CODE_W-1:0]            code_n,
    output logic                         grp_n,
    output logic                         en_out_n
);
    logic [SEL_W-1:0]    sel;
    logic [SLICE_CW-1:0] low_bits_n;

    // Combine the slice codes by AND and record which slice is encoding.
    always_comb begin
        sel        = '0;
        low_bits_n = '1;
        for (int s = 0; s < N_SLICES; s++) begin
            low_bits_n = low_bits_n & slice_code_n[s*SLICE_CW +: SLICE_CW];
            if (!slice_gs_n[s]) sel = sel | SEL_W'(s);
        end
    end

    // Assemble the wide outputs; the lowest slice supplies the pass-on.
    always_comb begin
        code_n   = {~sel, low_bits_n};
        grp_n    = &slice_gs_n;
        en_out_n = low_eo_n;
    end
endmodule

// File: rtl/prio_enc_chain.sv
// Wide active-low priority encoder built from chained eight-line slices.
// Assumes N_SLICES is a power of two and at least 2. Slice s covers
// req_n[8s+7:8s]. The enable enters the top slice and ripples down
// through each slice's eo_n.
module prio_enc_chain
    import prio_enc_pkg::*;
#(
    parameter int N_SLICES = 2,
    localparam int WIDTH   = N_SLICES * SLICE_W,
    localparam int CODE_W  = SLICE_CW + $clog2(N_SLICES)
) (
    input  logic [WIDTH-1:0]  req_n,
    input  logic              en_in_n,
    output logic [CODE_W-1:0] code_n,
    output logic              grp_n,
    output logic              en_out_n
);
    logic [N_SLICES*SLICE_CW-1:0] s_code_n;
    logic [N_SLICES-1:0]          s_gs_n;
    logic [N_SLICES:0]            chain_n;

    // The top of the enable chain is the block's enable input.
    assign chain_n[N_SLICES] = en_in_n;

    for (genvar s = 0; s < N_SLICES; s++) begin : g_slice
        prio_slice8 u_slice (
            .req_n  (req_n[s*SLICE_W +: SLICE_W]),
            .ei_n   (chain_n[s+1]),
            .code_n (s_code_n[s*SLICE_CW +: SLICE_CW]),
            .gs_n   (s_gs_n[s]),
            .eo_n   (chain_n[s])
        );
    end

    prio_merge #(.N_SLICES(N_SLICES)) u_merge (
        .slice_code_n (s_code_n),
        .slice_gs_n   (s_gs_n),
        .low_eo_n     (chain_n[0]),
        .code_n       (code_n),
        .grp_n        (grp_n),
        .en_out_n     (en_out_n)
    );
endmodule

// File: rtl/prio_enc_chain_chk.sv
// Checker for prio_enc_chain. The block is combinational, so the checks
// are immediate assertions evaluated whenever the ports settle.
module prio_enc_chain_chk #(
    parameter int N_SLICES = 2,
    localparam int WIDTH   = N_SLICES * 8,
    localparam int CODE_W  = 3 + $clog2(N_SLICES)
) (
    input logic [WIDTH-1:0]  req_n,
    input logic              en_in_n,
    input logic [CODE_W-1:0] code_n,
    input logic              grp_n,
    input logic              en_out_n
);
    logic [CODE_W-1:0] idx;

    // Relate the outputs to the requests and the enable.
    always_comb begin
        idx = ~code_n;
        if (en_in_n) begin
            p_disabled_high_r3: assert (code_n == '1 && grp_n && en_out_n)
                else $error("R3 outputs not high while disabled");
        end else begin
            p_grp_any_r4: assert (grp_n == (&req_n))
                else $error("R4 grp_n mismatch");
            p_pass_on_r5: assert (en_out_n == !(&req_n))
                else $error("R5 en_out_n mismatch");
        end
        if (grp_n) begin
            p_idle_code_r6: assert (code_n == '1)
                else $error("R6 code not all ones with no winner");
        end else begin
            p_winner_low_r1: assert (!req_n[idx])
                else $error("R1 encoded line not low");
            for (int j = 0; j < WIDTH; j++) begin
                if (j > int'(idx)) begin
                    p_higher_idle_r2: assert (req_n[j])
                        else $error("R2 higher line is low");
                end
            end
        end
    end
endmodule

bind prio_enc_chain prio_enc_chain_chk #(.N_SLICES(N_SLICES)) u_chk (
    .req_n    (req_n),
    .en_in_n  (en_in_n),
    .code_n   (code_n),
    .grp_n    (grp_n),
    .en_out_n (en_out_n)
);

// File: tb/prio_enc_chain_bench.sv
// Directed bench: one task per scenario. Inputs change on the rising edge
// and outputs are sampled on the falling edge.
module prio_enc_chain_bench;
    localparam int CLK_PERIOD = 10;
    localparam int NS = 2;
    localparam int W  = NS * 8;
    localparam int CW = 3 + $clog2(NS);

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    always #(CLK_PERIOD/2) clk = ~clk;

    logic [W-1:0]  req_n;
    logic          en_in_n;
    logic [CW-1:0] code_n;
    logic          grp_n, en_out_n;

    logic [7:0] s_req_n;
    logic       s_ei_n;
    logic [2:0] s_code_n;
    logic       s_gs_n, s_eo_n;

    int checks = 0;
    int failures = 0;

    prio_enc_chain #(.N_SLICES(NS)) u_prio_enc_chain (
        .req_n(req_n), .en_in_n(en_in_n), .code_n(code_n),
        .grp_n(grp_n), .en_out_n(en_out_n));

    prio_slice8 u_slice (
        .req_n(s_req_n), .ei_n(s_ei_n), .code_n(s_code_n),
        .gs_n(s_gs_n), .eo_n(s_eo_n));

    // Flat reference model: returns {code_n, grp_n, en_out_n}.
    function automatic logic [CW+1:0] ref_wide(input logic [W-1:0] r, input logic e_n);
        logic [CW-1:0] idx = '0;
        logic found = 1'b0;
        for (int i = 0; i < W; i++) if (!r[i]) begin idx = CW'(i); found = 1'b1; end
        if (e_n) return '1;
        return {found ? ~idx : {CW{1'b1}}, !found, found};
    endfunction

    function automatic logic [4:0] ref_slice(input logic [7:0] r, input logic e_n);
        logic [2:0] idx = '0;
        logic found = 1'b0;
        for (int i = 0; i < 8; i++) if (!r[i]) begin idx = 3'(i); found = 1'b1; end
        if (e_n) return '1;
        return {found ? ~idx : 3'b111, !found, found};
    endfunction

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            failures++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic apply_wide(input logic [W-1:0] r, input logic e_n);
        @(posedge clk);
        req_n = r; en_in_n = e_n;
        @(negedge clk);
    endtask

    task automatic check_wide(input string req);
        check(req, 32'({code_n, grp_n, en_out_n}), 32'(ref_wide(req_n, en_in_n)));
    endtask

    // R6/R5: enabled with no request.
    task automatic t_idle();
        apply_wide('1, 1'b0);
        check("R6 idle code", 32'(code_n), {32{1'b0}} | ((1 << CW) - 1));
        check("R5 idle en_out_n low", 32'(en_out_n), 32'd0);
        check("R4 idle grp_n high", 32'(grp_n), 32'd1);
    endtask

    // R3: disabled with requests present.
    task automatic t_disable();
        apply_wide(16'h0000, 1'b1);
        check("R3 disabled all high", 32'({code_n, grp_n, en_out_n}), (1 << (CW + 2)) - 1);
        apply_wide(16'hFEFF, 1'b1);
        check("R3 disabled one request", 32'({code_n, grp_n, en_out_n}), (1 << (CW + 2)) - 1);
    endtask

    // R9 with R1/R2/R4/R5/R7: every slice input with and without enable.
    task automatic t_slice_exhaustive();
        for (int v = 0; v < 512; v++) begin
            @(posedge clk);
            s_req_n = v[7:0]; s_ei_n = v[8];
            @(negedge clk);
            check("R9 slice exhaustive", 32'({s_code_n, s_gs_n, s_eo_n}), 32'(ref_slice(s_req_n, s_ei_n)));
        end
    endtask

    // R7: lower lines are don't-care below the winner.
    task automatic t_dont_care();
        apply_wide(16'hDFFF, 1'b0);
        check("R7 single line 13", 32'(code_n), 32'(~4'd13 & 4'hF));
        apply_wide(16'hD000, 1'b0);
        check("R7 lower lines low", 32'(code_n), 32'(~4'd13 & 4'hF));
        apply_wide(16'hFF7F, 1'b0);
        check("R7 line 7 alone", 32'(code_n), 32'(~4'd7 & 4'hF));
        apply_wide(16'hFF55, 1'b0);
        check("R7 line 7 with lower", 32'(code_n), 32'(~4'd7 & 4'hF));
    endtask

    // R8/R1/R2: walking zero across the full width.
    task automatic t_walking_zero();
        for (int i = 0; i < W; i++) begin
            apply_wide(~(W'(1) << i), 1'b0);
            check_wide("R8 walking zero");
            check("R1 index", 32'(~code_n & ((1 << CW) - 1)), 32'(i));
        end
    endtask

    // R8: random sweep, mostly sparse requests, enable toggled sometimes.
    task automatic t_random();
        for (int k = 0; k < 400; k++) begin
            logic [W-1:0] r = W'($urandom) | W'($urandom);
            apply_wide(r, ($urandom % 8) == 0);
            check_wide("R8 random");
        end
    endtask

    initial begin
        #(CLK_PERIOD * 200000);
        failures++;
        $display("FAIL watchdog expired");
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

    initial begin
        req_n = '1; en_in_n = 1'b1; s_req_n = '1; s_ei_n = 1'b1;
        repeat (2) @(posedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        check("R3 start disabled", 32'({code_n, grp_n, en_out_n}), (1 << (CW + 2)) - 1);
        t_idle();
        t_disable();
        t_slice_exhaustive();
        t_dont_care();
        t_walking_zero();
        t_random();
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end
endmodule